// File: doc/BRIEF.md
# Priority Message Injection Concentrator

This block sits at the entry of a bit-serial routing pipeline and fills up to seven output slots at the start of every routing pass. It has two groups of inputs. The first is one serial stream from each buffer row, carrying messages that earlier passes could not deliver. The second is one serial stream from each of sixteen local processors. Each stream begins with a message-present bit. The remaining bits of the message follow, one per clock.

The pass-start strobe marks the clock in which the present bits of all inputs are at the block. In that clock a two-dimensional priority chain decides which source drives which slot. Buffered messages are placed first. Processors take the slots that are still free. The switch setting is stored and held until the next strobe, so every later bit of a message follows the same path. Each slot output is registered, which gives one clock of latency. Processors whose offers were taken receive a one-clock acknowledge. Processors that were refused must offer their message again in a later pass.

Top module: `inj_concentrator`

## Requirements
- R1: During reset, and after reset until the first pass-start strobe, every bit of `slotBits` and `procAck` is 0.
- R2: Buffered rows whose present bit (`bufBits[j]` in the strobe clock) is 1 take slots 0, 1, 2, and so on, in ascending row order, before any processor is considered.
- R3: Processors whose present bit (`procBits[p]` in the strobe clock) is 1 take the free slots above the buffered ones in ascending processor index, while free slots remain. Slot k is bit k of `slotBits`, and slot 0 is the lowest-numbered slot.
- R4: The clock after a strobe, `procAck[p]` is 1 exactly for the processors that were given a slot. At every other time `procAck` is 0.
- R5: When all seven buffered rows are present, no processor is given a slot and no acknowledge is raised.
- R6: The setting chosen at a strobe is held until the next strobe. For every clock t from the strobe onward, `slotBits[k]` at t+1 equals the bit at t of the source assigned to slot k. Strobes in consecutive clocks are allowed.
- R7: A source whose present bit was 0 at the strobe does not reach any output for that pass, whatever its later bits are.
- R8: A slot with no assigned source outputs 0 in every clock of the pass, so its message-present bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one message bit per cycle |
| rstN | input | 1 | Asynchronous reset, active low |
| passStart | input | 1 | High in the clock that carries the message-present bits |
| bufBits | input | 7 | One serial bit from each buffer row |
| procBits | input | 16 | One serial bit from each processor |
| slotBits | output | 7 | Registered serial bit of each output slot |
| procAck | output | 16 | One-clock acknowledge to each processor that was given a slot |

## Verification
The assertions assume that `passStart` is low while reset is active and in the clock right after reset is released. This matters because several properties look back one clock to the strobe. The stimulus raises the first strobe only after a few idle cycles in reset-released state. The properties judge only the message-present bit-time, through slot counts, packing and acknowledge counts. The payload bits are judged by the bench's reference model. To exercise the rule that absent sources are ignored, the bench drives all ones on every stream that was absent at the strobe.

// File: rtl/inj_pkg.sv
package inj_pkg;

  // Strobes sent from the priority control to the switch datapath.
  typedef struct packed {
    logic latchSetting;  // present bits are here: capture a new switch setting
    logic issueAck;      // clock after a strobe: acknowledge granted processors
  } injStrobe_t;

endpackage

// File: rtl/inj_ctrl.sv
// Priority control. Runs the two-dimensional claim chain over all sources
// (buffer rows first, then processors in ascending index) and produces the
// strobes that drive the datapath.
module inj_ctrl
  import inj_pkg::*;
#(
  parameter int NUM_SLOTS = 7,
  parameter int NUM_PROCS = 16,
  localparam int NUM_SRC = NUM_SLOTS + NUM_PROCS
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                passStart,
  input  logic [NUM_SRC-1:0]                  srcPresent,
  output logic [NUM_SRC-1:0][NUM_SLOTS-1:0]   grantNext,
  output injStrobe_t                          strobe
);

  logic ackPend;

  // Claim chain. Each source walks the slot column. Because slots fill
  // from the bottom, the occupancy vector is always a thermometer. A
  // present source claims the lowest free slot, which is the one whose
  // lower neighbour is occupied. A source that finds no free slot is
  // refused.
  always_comb begin
    logic [NUM_SLOTS-1:0] occ;
    logic [NUM_SLOTS-1:0] lowerTaken;
    occ = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (NUM_SLOTS > 1)
        lowerTaken = {occ[NUM_SLOTS-2:0], 1'b1};
      else
        lowerTaken = '1;
      grantNext[s] = {NUM_SLOTS{srcPresent[s]}} & ~occ & lowerTaken;
      occ = occ | grantNext[s];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackPend <= 1'b0;
    else       ackPend <= passStart;
  end

  assign strobe.latchSetting = passStart;
  assign strobe.issueAck     = ackPend;

endmodule

// File: rtl/inj_xbar.sv
// Switch datapath: the held switch setting, the source-to-slot crossbar,
// the registered slot outputs and the acknowledge decode.
module inj_xbar
  import inj_pkg::*;
#(
  parameter int NUM_SLOTS = 7,
  parameter int NUM_PROCS = 16,
  localparam int NUM_SRC = NUM_SLOTS + NUM_PROCS
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  injStrobe_t                          strobe,
  input  logic [NUM_SRC-1:0][NUM_SLOTS-1:0]   grantNext,
  input  logic [NUM_SRC-1:0]                  srcBits,
  output logic [NUM_SLOTS-1:0]                slotBits,
  output logic [NUM_PROCS-1:0]                procAck
);

  logic [NUM_SRC-1:0][NUM_SLOTS-1:0] heldGrant;
  logic [NUM_SRC-1:0][NUM_SLOTS-1:0] activeGrant;
  logic [NUM_SLOTS-1:0]              slotNext;

  // The setting is captured at the strobe. In the strobe clock itself the
  // fresh setting already steers the present bits.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    heldGrant <= '0;
    else if (strobe.latchSetting) heldGrant <= grantNext;
  end

  always_comb activeGrant = strobe.latchSetting ? grantNext : heldGrant;

  // One OR column per slot. A slot with no source reduces to 0.
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    always_comb begin
      logic acc;
      acc = 1'b0;
      for (int s = 0; s < NUM_SRC; s++)
        acc = acc | (activeGrant[s][k] & srcBits[s]);
      slotNext[k] = acc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slotBits <= '0;
    else       slotBits <= slotNext;
  end

  // A processor is acknowledged when its row of the held setting is not
  // empty, only in the clock after the strobe.
  for (genvar p = 0; p < NUM_PROCS; p++) begin : g_ack
    assign procAck[p] = strobe.issueAck & (|heldGrant[NUM_SLOTS+p]);
  end

endmodule

// File: rtl/inj_concentrator.sv
module inj_concentrator
  import inj_pkg::*;
#(
  parameter int NUM_SLOTS = 7,
  parameter int NUM_PROCS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  passStart,
  input  logic [NUM_SLOTS-1:0]  bufBits,
  input  logic [NUM_PROCS-1:0]  procBits,
  output logic [NUM_SLOTS-1:0]  slotBits,
  output logic [NUM_PROCS-1:0]  procAck
);

  localparam int NUM_SRC = NUM_SLOTS + NUM_PROCS;

  // Buffer rows occupy the low source indices, so they win the chain.
  logic [NUM_SRC-1:0]                srcBits;
  logic [NUM_SRC-1:0][NUM_SLOTS-1:0] grantNext;
  injStrobe_t                        strobe;

  assign srcBits = {procBits, bufBits};

  inj_ctrl #(.NUM_SLOTS(NUM_SLOTS), .NUM_PROCS(NUM_PROCS)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .passStart  (passStart),
    .srcPresent (srcBits),
    .grantNext  (grantNext),
    .strobe     (strobe)
  );

  inj_xbar #(.NUM_SLOTS(NUM_SLOTS), .NUM_PROCS(NUM_PROCS)) xbar_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .grantNext (grantNext),
    .srcBits   (srcBits),
    .slotBits  (slotBits),
    .procAck   (procAck)
  );

endmodule

// File: rtl/inj_concentrator_chk.sv
module inj_concentrator_chk #(
  parameter int NUM_SLOTS = 7,
  parameter int NUM_PROCS = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  passStart,
  input logic [NUM_SLOTS-1:0]  bufBits,
  input logic [NUM_PROCS-1:0]  procBits,
  input logic [NUM_SLOTS-1:0]  slotBits,
  input logic [NUM_PROCS-1:0]  procAck
);

  int bufCntQ;
  int offerCntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufCntQ   <= 0;
      offerCntQ <= 0;
    end else begin
      bufCntQ   <= $countones(bufBits);
      offerCntQ <= $countones(bufBits) + $countones(procBits);
    end
  end

  // R4: acknowledges appear only in the clock after a strobe
  a_r4_ack_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (procAck != '0) |-> $past(passStart));

  // R4 / R7: only processors that offered at the strobe are acknowledged
  a_r4_ack_only_offered: assert property (@(posedge clk) disable iff (!rstN)
    passStart |=> ((procAck & ~$past(procBits)) == '0));

  // R5: a full set of buffered rows locks processors out
  a_r5_buffers_block_procs: assert property (@(posedge clk) disable iff (!rstN)
    (passStart && ($countones(bufBits) == NUM_SLOTS)) |=> (procAck == '0));

  // R2 / R3: present bits leave packed into the lowest slots
  a_r2_packed_slots: assert property (@(posedge clk) disable iff (!rstN)
    passStart |=> (((slotBits + 1'b1) & slotBits) == '0));

  // R3: slots used equal offers, saturated at the slot count
  a_r3_slot_count: assert property (@(posedge clk) disable iff (!rstN)
    passStart |=> ($countones(slotBits) ==
                   ((offerCntQ > NUM_SLOTS) ? NUM_SLOTS : offerCntQ)));

  // R4: acknowledge count equals the slots taken by processors
  a_r4_ack_count: assert property (@(posedge clk) disable iff (!rstN)
    passStart |=> ($countones(procAck) == $countones(slotBits) - bufCntQ));

endmodule

bind inj_concentrator inj_concentrator_chk #(
  .NUM_SLOTS(NUM_SLOTS),
  .NUM_PROCS(NUM_PROCS)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .passStart (passStart),
  .bufBits   (bufBits),
  .procBits  (procBits),
  .slotBits  (slotBits),
  .procAck   (procAck)
);

// File: tb/inj_concentrator_tb.sv
`timescale 1ns/100ps
module inj_concentrator_tb_top;

  localparam int NS = 7;
  localparam int NP = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          passStart = 1'b0;
  logic [NS-1:0] bufBits = '0;
  logic [NP-1:0] procBits = '0;
  logic [NS-1:0] slotBits;
  logic [NP-1:0] procAck;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;
  string curReq = "R1";

  // model state
  int            slotSrc [NS];
  int            q [$];
  logic [NS-1:0] expSlot = '0;
  logic [NP-1:0] expAck = '0;
  logic [NS-1:0] offBuf = '0;
  logic [NP-1:0] offProc = '0;

  always #2.5 clk = ~clk;

  inj_concentrator #(.NUM_SLOTS(NS), .NUM_PROCS(NP)) dut_i (
    .clk(clk), .rstN(rstN), .passStart(passStart),
    .bufBits(bufBits), .procBits(procBits),
    .slotBits(slotBits), .procAck(procAck)
  );

  function automatic logic srcBit(int s);
    return (s < NS) ? bufBits[s] : procBits[s-NS];
  endfunction

  // Behavioural reference: list the offers in priority order, hand out slots.
  always @(posedge clk) begin
    if (!rstN) begin
      foreach (slotSrc[k]) slotSrc[k] = -1;
      expSlot = '0;
      expAck  = '0;
    end else begin
      logic [NS-1:0] ns;
      logic [NP-1:0] na;
      ns = '0;
      na = '0;
      if (passStart) begin
        q.delete();
        for (int j = 0; j < NS; j++) if (bufBits[j]) q.push_back(j);
        for (int p = 0; p < NP; p++) if (procBits[p]) q.push_back(NS + p);
        for (int k = 0; k < NS; k++) begin
          slotSrc[k] = (k < q.size()) ? q[k] : -1;
          if (slotSrc[k] >= NS) na[slotSrc[k]-NS] = 1'b1;
        end
      end
      for (int k = 0; k < NS; k++) if (slotSrc[k] >= 0) ns[k] = srcBit(slotSrc[k]);
      expSlot = ns;
      expAck  = na;
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (slotBits !== expSlot) begin
        errors++;
        $display("FAIL %s slotBits actual %b expected %b", curReq, slotBits, expSlot);
      end
      checks++;
      if (procAck !== expAck) begin
        errors++;
        $display("FAIL %s procAck actual %b expected %b", curReq, procAck, expAck);
      end
    end
  end

  // One routing pass: strobe clock with present bits, then len payload clocks.
  // Present streams carry random payload; absent streams carry all ones.
  task automatic runPass(input logic [NS-1:0] bp, input logic [NP-1:0] pp,
                         input int len, input string req);
    @(negedge clk);
    curReq    = req;
    offBuf    = bp;
    offProc   = pp;
    passStart = 1'b1;
    bufBits   = bp;
    procBits  = pp;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      passStart = 1'b0;
      bufBits   = (NS'($urandom) & offBuf) | ~offBuf;
      procBits  = (NP'($urandom) & offProc) | ~offProc;
    end
  endtask

  task automatic explicitCount(input int wantAcks, input string req);
    // Called right after the strobe clock's following edge has been passed.
    checks++;
    if ($countones(procAck) != wantAcks) begin
      errors++;
      $display("FAIL %s ack count actual %0d expected %0d", req, $countones(procAck), wantAcks);
    end
  endtask

  initial begin
    curReq = "R1";
    repeat (4) @(negedge clk);
    checks++;
    if (slotBits !== '0 || procAck !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs actual %b/%b expected 0/0", slotBits, procAck);
    end
    rstN = 1'b1;
    bufBits  = '1;            // R1: activity without a strobe stays invisible
    procBits = '1;
    repeat (4) @(negedge clk);

    runPass(7'b1010010, 16'h0000, 8, "R2");
    runPass(7'b0000011, 16'h8421, 8, "R3");
    // R4: one buffered, all processors offer -> processors 0..5 acknowledged
    @(negedge clk);
    curReq = "R4"; passStart = 1'b1; bufBits = 7'b0001000; procBits = 16'hFFFF;
    offBuf = 7'b0001000; offProc = 16'hFFFF;
    @(negedge clk);
    passStart = 1'b0; bufBits = 7'b1110111; procBits = 16'h0000;
    explicitCount(6, "R4");
    repeat (4) @(negedge clk);
    // R5: all buffered present
    @(negedge clk);
    curReq = "R5"; passStart = 1'b1; bufBits = '1; procBits = 16'hFFFF;
    offBuf = '1; offProc = 16'hFFFF;
    @(negedge clk);
    passStart = 1'b0;
    explicitCount(0, "R5");
    repeat (4) @(negedge clk);
    runPass(7'b0000000, 16'h0000, 8, "R8");
    runPass(7'b0000000, 16'h0000, 8, "R7");
    runPass(7'b0100000, 16'h0010, 10, "R7");
    // R6: back-to-back strobes, then long holds
    runPass(7'b0000001, 16'h0001, 0, "R6");
    runPass(7'b0000010, 16'h0300, 0, "R6");
    runPass(7'b1111110, 16'h0002, 20, "R6");
    for (int n = 0; n < 200; n++)
      runPass(NS'($urandom), NP'($urandom), int'($urandom_range(0, 12)), "R6");
    @(negedge clk);
    passStart = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule